// File: doc/BRIEF.md
# Serial Line Transmitter with Break and Clear-to-Send

This block turns bytes into asynchronous serial frames on a single output line. The frame format and bit rate come from a configuration word that software may change at run time. The word selects the number of data bits, the parity mode, the number of stop bits and the number of clock cycles per bit. A byte is offered with a valid pulse and is taken on any clock edge where the block reports it is not busy. The block latches the configuration at that moment, so later changes do not disturb a frame in flight.

Two line-control features sit on top of plain framing.

- **Break request.** A break request forces the line low for as long as it is held. It aborts any frame in progress. When the request is released, the line goes high and stays high for one full bit time before another byte can start.
- **Flow control.** An active-low clear-to-send input holds off the next character while it is high. It is only looked at between characters, so a frame that has started always finishes. A configuration bit turns flow control off at run time. A build parameter removes it altogether.

Top module: `uart_tx_core`

## Requirements
- R1: Out of reset the line is high and `busy` is low.
- R2: A byte is taken on a rising edge where `tx_valid` is high and `busy` is low. From the next cycle `busy` stays high for exactly (frame bits × bit time) cycles, then falls unless something else is holding it.
- R3: A frame is a start bit of 0, then the data bits LSB first, then parity (if enabled), then stop bits of 1. The data length comes from `cfg_word[29:28]`: 0 gives 8 bits, 1 gives 7, 2 gives 6, 3 gives 5.
- R4: `cfg_word[26]`=1 adds a parity bit right after the data.
  - With `cfg_word[24]`=0, the parity bit makes the count of ones in data plus parity odd when `cfg_word[25]`=1, and even when it is 0.
  - With `cfg_word[24]`=1, the parity bit is the constant `cfg_word[25]`.
- R5: `cfg_word[27]`=1 sends two stop bits; 0 sends one.
- R6: Every bit lasts `cfg_word[23:0]` clock cycles; a value of 0 is treated as 1.
- R7: The configuration is captured when the byte is taken; changing `cfg_word` or `tx_byte` during a frame does not alter that frame.
- R8: With flow control active, `cts_n`=1 keeps `busy` high and no start bit begins. A frame already started completes unchanged.
- R9: `cfg_word[30]`=1 makes `cts_n` ignored; with parameter `FLOW_CTRL`=0 it is ignored whatever bit 30 holds.
- R10: While `brk_req` is high, `busy` is high and the line is low from the cycle after the request is first sampled. This happens even mid-frame, and valid strobes meanwhile are ignored.
- R11: After `brk_req` falls, the line is high and `busy` high for exactly one bit time (per the current `cfg_word[23:0]`), then `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word | input | 31 | Bit rate, length, parity, stop and flow-control setup |
| tx_valid | input | 1 | Byte offered this cycle |
| tx_byte | input | 8 | Byte to send |
| brk_req | input | 1 | Hold the line low while high |
| cts_n | input | 1 | Active-low clear-to-send, synchronous to clk |
| line_out | output | 1 | Serial output line, idles high |
| busy | output | 1 | High when a byte would not be taken |

## Verification
Most internal faults show up at the line within one bit time:
- a wrong bit counter or shift register moves, drops or repeats a bit;
- a bad bit timer stretches or shortens every bit from the start bit onward;
- a stale latched configuration breaks the frame whose setup is changed mid-flight.

A wrong end-of-frame decision shows on `busy` at the exact cycle the last stop bit ends. Faults in the break and recovery paths show on the cycle after the request changes, and again one bit time after release.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_BRK  = 2'd2,
        ST_RCV  = 2'd3
    } tx_state_e;

    // Configuration word field positions
    localparam int CFG_FC_OFF    = 30;
    localparam int CFG_LEN_HI    = 29;
    localparam int CFG_LEN_LO    = 28;
    localparam int CFG_TWO_STOP  = 27;
    localparam int CFG_PAR_EN    = 26;
    localparam int CFG_PAR_SENSE = 25;
    localparam int CFG_PAR_FIXED = 24;

endpackage

// File: rtl/uart_tx_bit_timer.sv
module uart_tx_bit_timer #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // R6
    tmr_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer #(
    parameter int MAX_DATA = 8,
    parameter int FRAME_W  = MAX_DATA + 4,
    parameter int CNT_W    = $clog2(FRAME_W + 1)
) (
    input  logic [MAX_DATA-1:0] data_in,
    input  logic [1:0]          len_code,
    input  logic                par_en,
    input  logic                par_sense,
    input  logic                par_fixed,
    input  logic                two_stop,
    output logic [FRAME_W-1:0]  frame,
    output logic [CNT_W-1:0]    nbits
);
    logic [FRAME_W-1:0] dpad;
    logic [CNT_W-1:0]   n_data;
    logic               par_bit;

    assign dpad = FRAME_W'(data_in);

    always_comb begin
        n_data  = CNT_W'(MAX_DATA) - CNT_W'(len_code);
        par_bit = par_sense;
        if (!par_fixed) begin
            for (int i = 0; i < MAX_DATA; i++)
                if (CNT_W'(i) < n_data) par_bit = par_bit ^ data_in[i];
        end
        frame    = '1;
        frame[0] = 1'b0;
        for (int i = 1; i < FRAME_W; i++) begin
            if (CNT_W'(i) <= n_data)
                frame[i] = dpad[i-1];
            else if (par_en && (CNT_W'(i) == n_data + 1'b1))
                frame[i] = par_bit;
        end
        nbits = n_data + CNT_W'(1) + CNT_W'(par_en)
              + (two_stop ? CNT_W'(2) : CNT_W'(1));
    end

endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
    import uart_tx_pkg::*;
#(
    parameter int CFG_W     = 31,
    parameter int DIV_W     = 24,
    parameter int MAX_DATA  = 8,
    parameter bit FLOW_CTRL = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CFG_W-1:0]    cfg_word,
    input  logic                tx_valid,
    input  logic [MAX_DATA-1:0] tx_byte,
    input  logic                brk_req,
    input  logic                cts_n,
    output logic                line_out,
    output logic                busy
);
    localparam int FRAME_W = MAX_DATA + 4;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    typedef struct packed {
        tx_state_e          st;
        logic               line;
        logic [FRAME_W-1:0] shreg;
        logic [CNT_W-1:0]   left;
        logic [DIV_W-1:0]   div_m1;
    } regs_t;

    regs_t r_d, r_q;

    logic               fc_on, hold, accept;
    logic [DIV_W-1:0]   div_cfg, div_m1_now;
    logic               tmr_load, tmr_done;
    logic [DIV_W-1:0]   tmr_val;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   nbits;

    uart_tx_framer #(
        .MAX_DATA (MAX_DATA),
        .FRAME_W  (FRAME_W),
        .CNT_W    (CNT_W)
    ) u_frm (
        .data_in   (tx_byte),
        .len_code  (cfg_word[CFG_LEN_HI:CFG_LEN_LO]),
        .par_en    (cfg_word[CFG_PAR_EN]),
        .par_sense (cfg_word[CFG_PAR_SENSE]),
        .par_fixed (cfg_word[CFG_PAR_FIXED]),
        .two_stop  (cfg_word[CFG_TWO_STOP]),
        .frame     (frame),
        .nbits     (nbits)
    );

    uart_tx_bit_timer #(.W(DIV_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    assign fc_on      = FLOW_CTRL && !cfg_word[CFG_FC_OFF];
    assign hold       = fc_on && cts_n;
    assign div_cfg    = cfg_word[DIV_W-1:0];
    assign div_m1_now = (div_cfg == '0) ? '0 : div_cfg - 1'b1;
    assign busy       = (r_q.st != ST_IDLE) || brk_req || hold;
    assign accept     = tx_valid && !busy;

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        tmr_val  = r_q.div_m1;
        if (brk_req) begin
            r_d.st   = ST_BRK;
            r_d.line = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_IDLE: begin
                    if (accept) begin
                        r_d.st     = ST_SEND;
                        r_d.shreg  = frame;
                        r_d.line   = frame[0];
                        r_d.left   = nbits;
                        r_d.div_m1 = div_m1_now;
                        tmr_load   = 1'b1;
                        tmr_val    = div_m1_now;
                    end
                end
                ST_SEND: begin
                    if (tmr_done) begin
                        if (r_q.left == CNT_W'(1)) begin
                            r_d.st   = ST_IDLE;
                            r_d.line = 1'b1;
                        end else begin
                            r_d.shreg = {1'b1, r_q.shreg[FRAME_W-1:1]};
                            r_d.line  = r_q.shreg[1];
                            r_d.left  = r_q.left - 1'b1;
                            tmr_load  = 1'b1;
                        end
                    end
                end
                ST_BRK: begin
                    r_d.st   = ST_RCV;
                    r_d.line = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = div_m1_now;
                end
                ST_RCV: begin
                    if (tmr_done) r_d.st = ST_IDLE;
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st     <= ST_IDLE;
            r_q.line   <= 1'b1;
            r_q.shreg  <= '1;
            r_q.left   <= '0;
            r_q.div_m1 <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign line_out = r_q.line;

    // R10
    brk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(brk_req)) |-> !line_out);

    // R3
    start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !line_out);

    // R2
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);

    // R8
    cts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && hold && !brk_req) |=> (line_out && r_q.st == ST_IDLE));

    // R11
    recover_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RCV) |-> (line_out && busy));

endmodule

// File: tb/uart_tx_core_tb.sv
module uart_tx_core_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [30:0] cfg_word;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic        brk_req;
    logic        cts_n;
    logic        line_out, busy;
    logic        line_nf, busy_nf;

    always #10 clk = ~clk;

    uart_tx_core u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .tx_valid(tx_valid),
        .tx_byte(tx_byte), .brk_req(brk_req), .cts_n(cts_n),
        .line_out(line_out), .busy(busy)
    );

    uart_tx_core #(.FLOW_CTRL(1'b0)) u_dut_nofc (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .tx_valid(tx_valid),
        .tx_byte(tx_byte), .brk_req(brk_req), .cts_n(cts_n),
        .line_out(line_nf), .busy(busy_nf)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL R2 watchdog expired: actual %0d cycles expected below %0d", cycles, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected frame: bits [11:0], bit count in [15:12]
    function automatic logic [15:0] exp_frame(input logic [7:0] d, input logic [30:0] cfg);
        logic [11:0] fr;
        int n, pos, nb;
        logic p;
        fr = '1;
        fr[0] = 1'b0;
        n = 8 - int'(cfg[29:28]);
        p = cfg[25];
        for (int i = 0; i < n; i++) begin
            fr[1+i] = d[i];
            if (!cfg[24]) p = p ^ d[i];
        end
        pos = 1 + n;
        if (cfg[26]) begin
            fr[pos] = p;
            pos++;
        end
        nb = pos + (cfg[27] ? 2 : 1);
        return {4'(nb), fr};
    endfunction

    function automatic int bit_time(input logic [30:0] cfg);
        return (cfg[23:0] == 24'd0) ? 1 : int'(cfg[23:0]);
    endfunction

    task automatic wait_ready();
        for (int w = 0; w < 100 && busy; w++) @(negedge clk);
    endtask

    // Called at a negedge
    task automatic send_frame(input logic [7:0] d, input logic [30:0] cfg,
                              input bit cts_mid, input bit cfg_mid, input string tag);
        logic [15:0] e;
        int nb, bt, bad_line, bad_busy;
        e  = exp_frame(d, cfg);
        nb = int'(e[15:12]);
        bt = bit_time(cfg);
        cfg_word = cfg;
        wait_ready();
        chk(busy === 1'b0, "R2", "ready before strobe", int'(busy), 0);
        tx_valid = 1'b1;
        tx_byte  = d;
        @(negedge clk);
        tx_valid = 1'b0;
        if (cfg_mid) begin
            cfg_word = cfg ^ 31'h3F00_0003;
            tx_byte  = ~d;
        end
        bad_line = 0;
        bad_busy = 0;
        for (int c = 0; c < nb * bt; c++) begin
            if (line_out !== e[c / bt]) bad_line++;
            if (busy !== 1'b1) bad_busy++;
            if (cts_mid && c == 1) cts_n = 1'b1;
            @(negedge clk);
        end
        chk(bad_line == 0, tag, "frame bit mismatches", bad_line, 0);
        chk(bad_busy == 0, "R2", "busy low inside frame", bad_busy, 0);
        chk(busy === cts_mid, cts_mid ? "R8" : "R2", "busy at frame end", int'(busy), int'(cts_mid));
        chk(line_out === 1'b1, "R3", "line idle after stop", int'(line_out), 1);
        if (cts_mid) cts_n = 1'b0;
        cfg_word = cfg;
    endtask

    initial begin
        logic [30:0] cfg;
        int bad, bt;
        void'($urandom(32'd20240611));
        rst_n    = 1'b0;
        cfg_word = 31'd25;
        tx_valid = 1'b0;
        tx_byte  = 8'h00;
        brk_req  = 1'b0;
        cts_n    = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(line_out === 1'b1, "R1", "line after reset", int'(line_out), 1);
        chk(busy === 1'b0, "R1", "busy after reset", int'(busy), 0);

        // R3 default 8N1, 25 clocks per bit
        send_frame(8'hA5, 31'd25, 0, 0, "R3");
        send_frame(8'h00, 31'd25, 0, 0, "R3");
        send_frame(8'hFF, 31'd3, 0, 0, "R6");
        // R6 zero divisor acts as one
        send_frame(8'h5C, 31'd0, 0, 0, "R6");
        // R4 parity modes
        send_frame(8'h01, {3'b000, 1'b0, 1'b1, 1'b0, 1'b0, 24'd2}, 0, 0, "R4");
        send_frame(8'h01, {3'b000, 1'b0, 1'b1, 1'b1, 1'b0, 24'd2}, 0, 0, "R4");
        send_frame(8'h03, {3'b000, 1'b0, 1'b1, 1'b1, 1'b1, 24'd2}, 0, 0, "R4");
        send_frame(8'h03, {3'b000, 1'b0, 1'b1, 1'b0, 1'b1, 24'd2}, 0, 0, "R4");
        // R5 two stop bits, R3 five data bits
        send_frame(8'hE7, {3'b011, 1'b1, 1'b0, 1'b0, 1'b0, 24'd3}, 0, 0, "R5");
        // R7 setup and data change during the frame
        send_frame(8'h96, {3'b001, 1'b1, 1'b1, 1'b0, 1'b0, 24'd4}, 0, 1, "R7");

        // R8 clear-to-send holds off a new character
        @(negedge clk);
        cfg_word = 31'd4;
        cts_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b1, "R8", "busy while cts_n high", int'(busy), 1);
        // R9 flow control compiled out ignores cts_n
        chk(busy_nf === 1'b0, "R9", "no-flow build busy with cts_n high", int'(busy_nf), 0);
        tx_valid = 1'b1;
        tx_byte  = 8'h00;
        bad = 0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (line_out !== 1'b1 || busy !== 1'b1) bad++;
        end
        tx_valid = 1'b0;
        chk(bad == 0, "R8", "start bit under cts_n high", bad, 0);
        cts_n = 1'b0;
        repeat (100) @(negedge clk);
        // R8 frame in progress completes when cts_n rises
        send_frame(8'h3C, 31'd5, 1, 0, "R8");
        // R9 setup bit 30 ignores cts_n
        cts_n = 1'b1;
        send_frame(8'hC3, {1'b1, 6'b0, 24'd3}, 0, 0, "R9");
        cts_n = 1'b0;

        // R10 break from idle, strobe ignored
        cfg = 31'd4;
        cfg_word = cfg;
        wait_ready();
        brk_req  = 1'b1;
        tx_valid = 1'b1;
        tx_byte  = 8'hFF;
        #1;
        chk(busy === 1'b1, "R10", "busy as break raised", int'(busy), 1);
        bad = 0;
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            if (line_out !== 1'b0 || busy !== 1'b1) bad++;
        end
        chk(bad == 0, "R10", "line low during break", bad, 0);
        brk_req  = 1'b0;
        tx_valid = 1'b0;
        // R11 one bit time high after release
        bt = bit_time(cfg);
        bad = 0;
        for (int c = 0; c < bt; c++) begin
            @(negedge clk);
            if (line_out !== 1'b1 || busy !== 1'b1) bad++;
        end
        chk(bad == 0, "R11", "recovery bit time", bad, 0);
        @(negedge clk);
        chk(busy === 1'b0, "R11", "busy after recovery", int'(busy), 0);
        chk(line_out === 1'b1, "R10", "strobe during break not sent", int'(line_out), 1);

        // R10 break aborts a frame in flight
        cfg_word = 31'd6;
        tx_valid = 1'b1;
        tx_byte  = 8'hFF;
        @(negedge clk);
        tx_valid = 1'b0;
        repeat (9) @(negedge clk);
        brk_req = 1'b1;
        @(negedge clk);
        chk(line_out === 1'b0, "R10", "line low after mid-frame break", int'(line_out), 0);
        repeat (3) @(negedge clk);
        brk_req = 1'b0;
        bad = 0;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            if (line_out !== 1'b1 || busy !== 1'b1) bad++;
        end
        chk(bad == 0, "R11", "recovery after abort", bad, 0);
        @(negedge clk);
        chk(busy === 1'b0, "R11", "ready after abort", int'(busy), 0);

        // R3 random formats and data
        for (int k = 0; k < 40; k++) begin
            cfg = {1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
                   1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                   1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                   24'($urandom_range(0, 6))};
            send_frame(8'($urandom_range(0, 255)), cfg, 0, k[2], "R3");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule